// File: doc/BRIEF.md
# Scalar FP32 Multiply Lane

This unit multiplies the lowest single-precision element of two vector operands and places the product in the low 32 bits of a 256-bit result vector. The rest of the result vector comes from one of two merge policies. In legacy merge the first operand is also the destination, so all bits above the product are passed through from it. In extended merge the remaining bits of the low 128-bit lane come from the first operand and every bit above the lane is cleared.

The second multiplicand is a single 32-bit value. It is taken either from the low element of a vector operand or from a 32-bit memory word, chosen by a select input. The product is rounded to nearest, ties to even. Subnormal inputs are kept as subnormal values and are not flushed to zero. Five exception flags come with each result.

The result, the flags and the valid strobe are registered once. They appear on the clock edge after the one that samples the input strobe.

Top module: `fp32_mul_lane`

## Requirements
- R1: `valid_o` rises exactly one clock after each cycle with `valid_i` high and is low otherwise. While `rst_ni` is low, `valid_o` and `res_o` read zero.
- R2: Only bits [31:0] of the first operand and of the chosen second source affect the product, which appears in `res_o[31:0]`. The upper bits of `src2_i` never reach the result.
- R3: With `ext_mode_i` = 0, `res_o[255:32]` equals `src1_i[255:32]` as sampled with the input strobe.
- R4: With `ext_mode_i` = 1, `res_o[127:32]` equals `src1_i[127:32]` and `res_o[255:128]` is zero.
- R5: With `mem_sel_i` = 1 the second multiplicand is `mem_i`; with `mem_sel_i` = 0 it is `src2_i[31:0]`.
- R6: Finite products are rounded to nearest-even. `inx_o` is set whenever the rounded value differs from the exact one.
- R7: A rounded magnitude at or beyond 2^128 gives an infinity with the XOR sign, encoded with exponent field 0xFF and a zero fraction, and sets both `ovf_o` and `inx_o`.
- R8: Tiny results are produced as gradual subnormals. A result counts as tiny when its biased exponent is below 1 before rounding. `unf_o` is set when a result is both tiny and inexact.
- R9: Zero times infinity, or any signalling NaN operand, sets `inv_o` and gives 0xFFC00000. A signalling NaN has exponent 0xFF, a nonzero fraction and fraction bit 22 clear.
- R10: With no invalid case and a quiet NaN among the operands, the result is the first quiet NaN operand unchanged, with the first operand checked first. Such a result raises no flags apart from `den_o`.
- R11: `den_o` is set whenever either multiplicand has a zero exponent field and a nonzero fraction.
- R12: A zero or infinite result carries the XOR of the two operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| ext_mode_i | input | 1 | 1: extended merge (clear above lane), 0: legacy merge |
| mem_sel_i | input | 1 | 1: second multiplicand from `mem_i` |
| src1_i | input | 256 | First operand, also the destination in legacy merge |
| src2_i | input | 256 | Second vector operand; only bits [31:0] are used |
| mem_i | input | 32 | Second multiplicand from memory |
| valid_o | output | 1 | Result strobe |
| res_o | output | 256 | Merged result vector |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| inv_o | output | 1 | Invalid-operation flag |
| inx_o | output | 1 | Precision (inexact) flag |
| den_o | output | 1 | Denormal-operand flag |

## Verification
The assertions assume that `valid_i` is low while reset is held. They also assume that `ext_mode_i` and `src1_i` are meaningful only in cycles where the strobe is high, because the merge properties compare the output against the inputs of the strobe cycle. The stimulus changes every input on the falling clock edge and holds reset for several cycles with the strobe low. It fills unused vector bits with random data, so pass-through and clearing can be seen against real values and not zeros. Flag and NaN expectations come from hand-worked encodings chosen so that every rounding tie, overflow, underflow and special-value path is hit at least once.

// File: rtl/fp32_mul_pkg.sv
`timescale 1ns/1ps
package fp32_mul_pkg;
  localparam int unsigned FP_W   = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned MANT_W = FRAC_W + 1;
  localparam int unsigned PROD_W = 2 * MANT_W;
  localparam int unsigned LZ_W   = $clog2(MANT_W);
  localparam int unsigned SEXP_W = 12;

  localparam logic signed [SEXP_W-1:0] BIAS_S  = 12'sd127;
  localparam logic signed [SEXP_W-1:0] EMIN_S  = -12'sd126;
  localparam logic [FP_W-1:0]          DEF_QNAN = 32'hFFC0_0000;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } fp_class_e;

  typedef struct packed {
    logic                     sign;
    fp_class_e                cls;
    logic signed [SEXP_W-1:0] exp;   // unbiased, after normalisation
    logic [MANT_W-1:0]        mant;  // leading one at MSB for finite nonzero
  } fp_unp_t;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inv;
    logic inx;
    logic den;
  } fp_flags_t;
endpackage

// File: rtl/fp32_unpack.sv
`timescale 1ns/1ps
module fp32_unpack
  import fp32_mul_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output fp_unp_t         unp_o
);
  logic [EXP_W-1:0]  exp_fld;
  logic [FRAC_W-1:0] frac_fld;
  logic [MANT_W-1:0] frac_ext;
  logic [LZ_W-1:0]   lz;

  assign exp_fld  = val_i[FP_W-2 -: EXP_W];
  assign frac_fld = val_i[FRAC_W-1:0];
  assign frac_ext = {1'b0, frac_fld};

  // highest set bit wins
  always_comb begin
    lz = '0;
    for (int i = 0; i < MANT_W; i++) begin
      if (frac_ext[i]) lz = LZ_W'(MANT_W - 1 - i);
    end
  end

  always_comb begin
    unp_o      = '0;
    unp_o.sign = val_i[FP_W-1];
    unp_o.cls  = CLS_NORM;
    if (&exp_fld) begin
      if (frac_fld == '0)         unp_o.cls = CLS_INF;
      else if (frac_fld[FRAC_W-1]) unp_o.cls = CLS_QNAN;
      else                         unp_o.cls = CLS_SNAN;
    end else if (exp_fld == '0) begin
      if (frac_fld == '0) begin
        unp_o.cls = CLS_ZERO;
      end else begin
        unp_o.cls  = CLS_SUB;
        unp_o.mant = frac_ext << lz;
        unp_o.exp  = EMIN_S - SEXP_W'(lz);
      end
    end else begin
      unp_o.mant = {1'b1, frac_fld};
      unp_o.exp  = SEXP_W'(exp_fld) - BIAS_S;
    end
  end
endmodule

// File: rtl/fp32_mul_core.sv
`timescale 1ns/1ps
module fp32_mul_core
  import fp32_mul_pkg::*;
(
  input  logic [FP_W-1:0] a_raw_i,
  input  logic [FP_W-1:0] b_raw_i,
  input  fp_unp_t         a_i,
  input  fp_unp_t         b_i,
  output logic [FP_W-1:0] res_o,
  output fp_flags_t       flags_o
);
  localparam logic [FP_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam int unsigned     SH_W    = $clog2(PROD_W);
  localparam int unsigned     MAG_W   = FP_W + 2;

  logic [PROD_W-1:0]        prod, prod_n, shifted, lost_mask;
  logic signed [SEXP_W-1:0] e_sum, e_bias, sh_full;
  logic [SH_W-1:0]          sh;
  logic                     tiny, lost, guard, sticky, rnd_up, inexact, sgn;
  logic [MANT_W-1:0]        mant_t;
  logic [MANT_W:0]          mant_r;
  logic [EXP_W+1:0]         exp_fld;
  logic [MAG_W-1:0]         mag;
  logic                     a_nan, b_nan, zero_inf;

  // finite datapath
  always_comb begin
    prod = a_i.mant * b_i.mant;
    if (prod[PROD_W-1]) begin
      prod_n = prod;
      e_sum  = a_i.exp + b_i.exp + 12'sd1;
    end else begin
      prod_n = prod << 1;
      e_sum  = a_i.exp + b_i.exp;
    end
    e_bias    = e_sum + BIAS_S;
    tiny      = e_bias < 12'sd1;
    sh_full   = 12'sd1 - e_bias;
    sh        = sh_full[SH_W-1:0];
    lost_mask = (PROD_W'(1) << sh) - PROD_W'(1);
    if (!tiny) begin
      shifted = prod_n;
      lost    = 1'b0;
    end else if (sh_full >= SEXP_W'(PROD_W)) begin
      shifted = '0;
      lost    = |prod_n;
    end else begin
      shifted = prod_n >> sh;
      lost    = |(prod_n & lost_mask);
    end
    mant_t  = shifted[PROD_W-1 -: MANT_W];
    guard   = shifted[MANT_W-1];
    sticky  = (|shifted[MANT_W-2:0]) | lost;
    rnd_up  = guard & (sticky | mant_t[0]);
    inexact = guard | sticky;
    mant_r  = {1'b0, mant_t} + (MANT_W+1)'(rnd_up);
    exp_fld = tiny ? '0 : (EXP_W+2)'(e_bias - 12'sd1);
    // implicit one (and rounding carry) add into the exponent field
    mag     = (MAG_W'(exp_fld) << FRAC_W) + MAG_W'(mant_r);
  end

  assign sgn      = a_i.sign ^ b_i.sign;
  assign a_nan    = (a_i.cls == CLS_QNAN) || (a_i.cls == CLS_SNAN);
  assign b_nan    = (b_i.cls == CLS_QNAN) || (b_i.cls == CLS_SNAN);
  assign zero_inf = (a_i.cls == CLS_ZERO && b_i.cls == CLS_INF) ||
                    (a_i.cls == CLS_INF  && b_i.cls == CLS_ZERO);

  // special-case priority
  always_comb begin
    flags_o     = '0;
    flags_o.den = (a_i.cls == CLS_SUB) || (b_i.cls == CLS_SUB);
    if (a_i.cls == CLS_SNAN || b_i.cls == CLS_SNAN || zero_inf) begin
      res_o       = DEF_QNAN;
      flags_o.inv = 1'b1;
    end else if (a_nan) begin
      res_o = a_raw_i;
    end else if (b_nan) begin
      res_o = b_raw_i;
    end else if (a_i.cls == CLS_INF || b_i.cls == CLS_INF) begin
      res_o = {sgn, INF_MAG};
    end else if (a_i.cls == CLS_ZERO || b_i.cls == CLS_ZERO) begin
      res_o = {sgn, {(FP_W-1){1'b0}}};
    end else if (mag >= MAG_W'(INF_MAG)) begin
      res_o       = {sgn, INF_MAG};
      flags_o.ovf = 1'b1;
      flags_o.inx = 1'b1;
    end else begin
      res_o       = {sgn, mag[FP_W-2:0]};
      flags_o.inx = inexact;
      flags_o.unf = tiny & inexact;
    end
  end

  logic unused_mag_hi;
  assign unused_mag_hi = ^mag[MAG_W-1:FP_W-1];
endmodule

// File: rtl/vec_merge.sv
`timescale 1ns/1ps
module vec_merge #(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128,
  parameter int unsigned ELEM_W = 32
) (
  input  logic              ext_mode_i,
  input  logic [VEC_W-1:0]  src1_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic [VEC_W-1:0]  res_o
);
  localparam int unsigned N_ELEM = VEC_W / ELEM_W;

  for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
    if (k == 0) begin : g_low
      assign res_o[ELEM_W-1:0] = elem_i;
    end else if (k * ELEM_W < LANE_W) begin : g_lane
      assign res_o[k*ELEM_W +: ELEM_W] = src1_i[k*ELEM_W +: ELEM_W];
    end else begin : g_upper
      assign res_o[k*ELEM_W +: ELEM_W] =
        ext_mode_i ? '0 : src1_i[k*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/fp32_mul_lane.sv
`timescale 1ns/1ps
module fp32_mul_lane
  import fp32_mul_pkg::*;
#(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ext_mode_i,
  input  logic             mem_sel_i,
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [FP_W-1:0]  mem_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             inv_o,
  output logic             inx_o,
  output logic             den_o
);
  logic [FP_W-1:0]  b_raw, prod;
  fp_unp_t          a_unp, b_unp;
  fp_flags_t        flags_d, flags_q;
  logic [VEC_W-1:0] merged, res_q;
  logic             valid_q;

  assign b_raw = mem_sel_i ? mem_i : src2_i[FP_W-1:0];

  fp32_unpack u_unp_a (.val_i(src1_i[FP_W-1:0]), .unp_o(a_unp));
  fp32_unpack u_unp_b (.val_i(b_raw),            .unp_o(b_unp));

  fp32_mul_core u_core (
    .a_raw_i (src1_i[FP_W-1:0]),
    .b_raw_i (b_raw),
    .a_i     (a_unp),
    .b_i     (b_unp),
    .res_o   (prod),
    .flags_o (flags_d)
  );

  vec_merge #(.VEC_W(VEC_W), .LANE_W(LANE_W), .ELEM_W(FP_W)) u_merge (
    .ext_mode_i (ext_mode_i),
    .src1_i     (src1_i),
    .elem_i     (prod),
    .res_o      (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        res_q   <= merged;
        flags_q <= flags_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;
  assign ovf_o   = flags_q.ovf;
  assign unf_o   = flags_q.unf;
  assign inv_o   = flags_q.inv;
  assign inx_o   = flags_q.inx;
  assign den_o   = flags_q.den;

  logic unused_src2_hi;
  assign unused_src2_hi = ^src2_i[VEC_W-1:FP_W];
endmodule

// File: rtl/fp32_mul_lane_chk.sv
`timescale 1ns/1ps
module fp32_mul_lane_chk #(
  parameter int unsigned VEC_W  = 256,
  parameter int unsigned LANE_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             ext_mode_i,
  input logic [VEC_W-1:0] src1_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] res_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             inv_o,
  input logic             inx_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_LEGACY_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ext_mode_i |=> res_o[VEC_W-1:32] == $past(src1_i[VEC_W-1:32])); // R3
  AST_EXT_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ext_mode_i |=> res_o[LANE_W-1:32] == $past(src1_i[LANE_W-1:32])); // R4
  AST_EXT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ext_mode_i |=> res_o[VEC_W-1:LANE_W] == '0); // R4
  AST_OVF_INF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ovf_o |-> res_o[30:0] == 31'h7F80_0000 && inx_o); // R7
  AST_UNF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && unf_o |-> inx_o); // R8
  AST_INV_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && inv_o |-> res_o[31:0] == 32'hFFC0_0000); // R9
endmodule

bind fp32_mul_lane fp32_mul_lane_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .ext_mode_i (ext_mode_i),
  .src1_i     (src1_i),
  .valid_o    (valid_o),
  .res_o      (res_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o),
  .inv_o      (inv_o),
  .inx_o      (inx_o)
);

// File: tb/fp32_mul_lane_tb.sv
`timescale 1ns/1ps
module fp32_mul_lane_tb_top;
  localparam int unsigned VEC_W  = 256;
  localparam int unsigned LANE_W = 128;
  // flag vector order {ovf, unf, inv, inx, den}
  localparam logic [4:0] F_O = 5'b10000, F_U = 5'b01000, F_I = 5'b00100,
                         F_P = 5'b00010, F_D = 5'b00001, F_0 = 5'b00000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0, ext_mode = 1'b0, mem_sel = 1'b0;
  logic [VEC_W-1:0] src1 = '0, src2 = '0;
  logic [31:0]      mem = '0;
  logic             valid_o, ovf, unf, inv, inx, den;
  logic [VEC_W-1:0] res;

  always #2 clk = ~clk;

  fp32_mul_lane #(.VEC_W(VEC_W), .LANE_W(LANE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ext_mode_i(ext_mode),
    .mem_sel_i(mem_sel), .src1_i(src1), .src2_i(src2), .mem_i(mem),
    .valid_o(valid_o), .res_o(res), .ovf_o(ovf), .unf_o(unf), .inv_o(inv),
    .inx_o(inx), .den_o(den)
  );

  typedef struct {
    logic [VEC_W-1:0] res;
    logic [4:0]       fl;
    string            req;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_item;
  int   checks = 0, fails = 0, pushed = 0, popped = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // driver: one operation per call, back-to-back unless idle() is called
  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic ext, input logic use_mem,
                       input logic [31:0] exp_res, input logic [4:0] exp_fl,
                       input string req);
    exp_t it;
    logic [VEC_W-1:0] s1, s2;
    s1 = rnd_vec();
    s2 = rnd_vec();
    s1[31:0] = a;
    @(negedge clk);
    if (use_mem) mem = b; else begin s2[31:0] = b; mem = $urandom; end
    src1 = s1; src2 = s2; ext_mode = ext; mem_sel = use_mem; valid_i = 1'b1;
    it.res = s1;
    it.res[31:0] = exp_res;
    if (ext) it.res[VEC_W-1:LANE_W] = '0;
    it.fl  = exp_fl;
    it.req = req;
    sb_q.push_back(it);
    pushed++;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    valid_i = 1'b0;
    src1 = rnd_vec();
    repeat (n) begin
      @(negedge clk);
      check(valid_o == 1'b0, "R1", "valid during idle", VEC_W'(valid_o), '0);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R1", "unexpected result", res, '0);
      end else begin
        mon_item = sb_q.pop_front();
        popped++;
        check(res == mon_item.res, mon_item.req, "result", res, mon_item.res);
        check({ovf, unf, inv, inx, den} == mon_item.fl, mon_item.req, "flags",
              VEC_W'({ovf, unf, inv, inx, den}), VEC_W'(mon_item.fl));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && res == '0, "R1", "reset state", res, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0, "R1", "after reset", VEC_W'(valid_o), '0);

    // R2 R3: plain product, legacy merge, random upper bits everywhere
    drive(32'h4000_0000, 32'h4040_0000, 1'b0, 1'b0, 32'h40C0_0000, F_0, "R2");
    // R4: extended merge
    drive(32'h3FC0_0000, 32'hC000_0000, 1'b1, 1'b0, 32'hC040_0000, F_0, "R4");
    // R5: second multiplicand from memory
    drive(32'h3FC0_0000, 32'hC000_0000, 1'b0, 1'b1, 32'hC040_0000, F_0, "R5");
    drive(32'h4000_0000, 32'h4040_0000, 1'b1, 1'b1, 32'h40C0_0000, F_0, "R5");
    idle(3);
    // R6: inexact, rounds down
    drive(32'h3F80_0001, 32'h3F80_0001, 1'b0, 1'b0, 32'h3F80_0002, F_P, "R6");
    // R7: overflow both signs
    drive(32'h7F00_0000, 32'h4000_0000, 1'b0, 1'b0, 32'h7F80_0000, F_O | F_P, "R7");
    drive(32'hFF00_0000, 32'h4000_0000, 1'b1, 1'b0, 32'hFF80_0000, F_O | F_P, "R7");
    // R8: ties in subnormal range, and exact subnormal result
    drive(32'h0000_0001, 32'h3F00_0000, 1'b0, 1'b0, 32'h0000_0000, F_D | F_U | F_P, "R8");
    drive(32'h0000_0003, 32'h3F00_0000, 1'b1, 1'b0, 32'h0000_0002, F_D | F_U | F_P, "R8");
    drive(32'h0080_0000, 32'h3F00_0000, 1'b0, 1'b1, 32'h0040_0000, F_0, "R8");
    idle(2);
    // R9: invalid cases
    drive(32'h0000_0000, 32'h7F80_0000, 1'b0, 1'b0, 32'hFFC0_0000, F_I, "R9");
    drive(32'h7F80_0001, 32'h3F80_0000, 1'b1, 1'b0, 32'hFFC0_0000, F_I, "R9");
    drive(32'h7FC0_0000, 32'hFF80_0005, 1'b0, 1'b1, 32'hFFC0_0000, F_I, "R9");
    // R10: quiet NaN propagation
    drive(32'h3F80_0000, 32'h7FC1_2345, 1'b0, 1'b0, 32'h7FC1_2345, F_0, "R10");
    drive(32'hFFC0_0001, 32'h7FC0_0002, 1'b1, 1'b0, 32'hFFC0_0001, F_0, "R10");
    // R11: denormal operands kept, not flushed
    drive(32'h0000_0001, 32'h4000_0000, 1'b0, 1'b0, 32'h0000_0002, F_D, "R11");
    drive(32'h0000_0000, 32'h0000_0001, 1'b1, 1'b0, 32'h0000_0000, F_D, "R11");
    // R12: signs of zero and infinity
    drive(32'h8000_0000, 32'h3F80_0000, 1'b0, 1'b0, 32'h8000_0000, F_0, "R12");
    drive(32'h0000_0000, 32'hBF80_0000, 1'b1, 1'b1, 32'h8000_0000, F_0, "R12");
    drive(32'h7F80_0000, 32'hC000_0000, 1'b0, 1'b0, 32'hFF80_0000, F_0, "R12");
    idle(4);

    check(pushed == popped, "R1", "result count", VEC_W'(popped), VEC_W'(pushed));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule